// File: doc/BRIEF.md
# Biphase Data-Line Word Decoder

This block turns the sliced bit stream of one biphase-coded data line into a 40-bit result. The line is carried on a chosen video line of the first field. An upstream slicer supplies one data level per half-bit, together with a clock enable that marks each half-bit sample. The upstream timing supplies a pulse when the target line begins, and a pulse when a new first field begins.

The line holds fifteen bytes. Byte 1 is a run-in and byte 2 is a start code. Bytes 3 to 15 are payload. Once armed, the decoder searches the half-bit stream for the start code for a limited time. After a match it pairs the following half-bits into data bits, checks each pair for a biphase violation and counts the payload bytes. Five of those bytes are kept: the contiguous group 11 to 14, then byte 5. The decoder presents these as one 40-bit word with the group first and byte 5 last. The word is released only when the payload carried no violation. An active-low availability output tells a host that a fresh word is waiting. It also gives a short low pulse at every line start, so that a falling edge is always present for triggering.

Top module: `vline_word_decoder`

## Requirements
- R1: Decoding starts only after a `line_arm` pulse. Half-bits that arrive while the block is not armed produce no result. A new `line_arm` restarts the search and discards any line in progress.
- R2: While armed, the block looks for the start code at any half-bit alignment. It compares the last 16 half-bits with the biphase image of `START_CODE` (value 8'h5D by default, MSB first, a 1 sent as half-bits 1 then 0, a 0 sent as 0 then 1). If no match occurs within `SEARCH_HALVES` half-bits (160 by default), the line is abandoned.
- R3: After the match, each pair of half-bits forms one data bit: pair 1,0 gives 1 and pair 0,1 gives 0. Each group of 8 bits forms one byte, MSB first. These bytes are payload bytes 3 to 15. Only bytes 5 and 11 to 14 affect the result.
- R4: `word_data` bits [39:32] hold byte 11, [31:24] byte 12, [23:16] byte 13, [15:8] byte 14 and [7:0] byte 5. The bit values are unchanged.
- R5: `word_valid` is high for exactly one cycle, the cycle after the clock edge that takes the second half-bit of byte 15. `word_data` takes its new value at that same edge and is otherwise held.
- R6: A pair with equal halves anywhere in payload bytes 3 to 15 suppresses `word_valid` for that line, and `word_data` keeps its previous value.
- R7: `avail_n` goes low one cycle after `word_valid`. It stays low until a `field_start` pulse, which raises it again from the following cycle.
- R8: Each `line_arm` pulse drives `avail_n` low for `PULSE_CYC` cycles (20 by default), starting the cycle after the pulse.
- R9: After reset `avail_n` is high, `word_valid` is low and `word_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_start | input | 1 | One-cycle pulse at the start of a first field |
| line_arm | input | 1 | One-cycle pulse at the start of the target line in the first field |
| half_en | input | 1 | Clock enable marking one half-bit sample |
| half_bit | input | 1 | Sliced data level for the current half-bit |
| word_valid | output | 1 | One-cycle strobe for a line decoded without error |
| word_data | output | 40 | Last error-free result: bytes 11, 12, 13, 14, then byte 5 |
| avail_n | output | 1 | Active-low availability flag, with a low pulse at every line start |

## Verification
The strobe is due one cycle after the clock edge that samples the final half-bit of byte 15. `word_data` changes at that same edge. `avail_n` follows one cycle later. The line-start pulse appears one cycle after `line_arm` and lasts `PULSE_CYC` cycles. The bench drives each half-bit at a falling clock edge and then waits three more falling edges before the next one. It reads the strobe count and the data only after the last half-bit's window has closed, which is at least two edges past the point where the strobe and the flag settle. The pulse length is checked at its last low cycle and at its first high cycle, counted in falling edges from the arm pulse.

// File: rtl/vline_pkg.sv
package vline_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA
    } seq_state_e;

    // Biphase image of one byte, MSB first: a 1 becomes halves 1,0 and a 0 becomes 0,1.
    function automatic logic [2*BYTE_W-1:0] bp_encode(input logic [BYTE_W-1:0] b);
        logic [2*BYTE_W-1:0] e;
        for (int i = 0; i < BYTE_W; i++) begin
            e[2*i+1 -: 2] = b[i] ? 2'b10 : 2'b01;
        end
        return e;
    endfunction

endpackage

// File: rtl/bp_pair_decoder.sv
module bp_pair_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    input  logic half_en_i,
    input  logic half_i,
    output logic bit_stb_o,
    output logic bit_o,
    output logic bit_err_o
);

    typedef struct packed {
        logic phase;
        logic first;
    } pair_t;

    pair_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        bit_stb_o = 1'b0;
        bit_o     = r_q.first;
        bit_err_o = 1'b0;
        if (resync_i) begin
            r_d.phase = 1'b0;
        end else if (half_en_i) begin
            if (!r_q.phase) begin
                r_d.first = half_i;
                r_d.phase = 1'b1;
            end else begin
                r_d.phase = 1'b0;
                bit_stb_o = 1'b1;
                bit_err_o = (r_q.first == half_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // A decoded bit always closes a pair whose first half came from an earlier cycle (R3)
    p_bit_after_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> (r_q.phase && half_en_i));

endmodule

// File: rtl/line_sequencer.sv
module line_sequencer
    import vline_pkg::*;
#(
    parameter logic [BYTE_W-1:0] START_CODE    = 8'h5D,
    parameter int                SEARCH_HALVES = 160,
    parameter int                LINE_WORDS    = 15,
    parameter int                FIRST_PAYLOAD = 3,
    parameter int                SET_LO        = 11,
    parameter int                SET_HI        = 14,
    parameter int                SOLO_WORD     = 5,
    localparam int               NSLOT         = SET_HI - SET_LO + 2,
    localparam int               CAP_W         = NSLOT * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_arm_i,
    input  logic             half_en_i,
    input  logic             half_i,
    input  logic             bit_stb_i,
    input  logic             bit_i,
    input  logic             bit_err_i,
    output logic             resync_o,
    output logic             valid_o,
    output logic [CAP_W-1:0] data_o
);

    localparam int CNT_W  = $clog2(SEARCH_HALVES + 1);
    localparam int WIDX_W = $clog2(LINE_WORDS + 1);
    localparam int BIDX_W = $clog2(BYTE_W);
    localparam logic [2*BYTE_W-1:0] CODE_IMG = bp_encode(START_CODE);

    typedef struct packed {
        seq_state_e          state;
        logic [2*BYTE_W-1:0] hunt_sr;
        logic [CNT_W-1:0]    hunt_cnt;
        logic [WIDX_W-1:0]   word_idx;
        logic [BIDX_W-1:0]   bit_idx;
        logic [BYTE_W-1:0]   byte_sr;
        logic                err;
        logic [CAP_W-1:0]    stage;
        logic                valid;
        logic [CAP_W-1:0]    data;
    } seq_t;

    seq_t s_d, s_q;

    logic [2*BYTE_W-1:0] hunt_nx;
    logic [BYTE_W-1:0]   byte_nx;
    logic                slot_hit;
    int                  slot;

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        hunt_nx  = {s_q.hunt_sr[2*BYTE_W-2:0], half_i};
        byte_nx  = {s_q.byte_sr[BYTE_W-2:0], bit_i};
        slot_hit = 1'b0;
        slot     = 0;
        if (s_q.word_idx >= WIDX_W'(SET_LO) && s_q.word_idx <= WIDX_W'(SET_HI)) begin
            slot_hit = 1'b1;
            slot     = int'(s_q.word_idx) - SET_LO;
        end else if (s_q.word_idx == WIDX_W'(SOLO_WORD)) begin
            slot_hit = 1'b1;
            slot     = NSLOT - 1;
        end

        unique case (s_q.state)
            ST_IDLE: ;
            ST_HUNT: begin
                if (half_en_i) begin
                    s_d.hunt_sr = hunt_nx;
                    if (hunt_nx == CODE_IMG) begin
                        s_d.state    = ST_DATA;
                        s_d.word_idx = WIDX_W'(FIRST_PAYLOAD);
                        s_d.bit_idx  = '0;
                        s_d.err      = 1'b0;
                    end else if (s_q.hunt_cnt == CNT_W'(SEARCH_HALVES - 1)) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.hunt_cnt = s_q.hunt_cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_stb_i) begin
                    s_d.byte_sr = byte_nx;
                    s_d.err     = s_q.err | bit_err_i;
                    if (s_q.bit_idx == BIDX_W'(BYTE_W - 1)) begin
                        s_d.bit_idx = '0;
                        for (int s = 0; s < NSLOT; s++) begin
                            if (slot_hit && slot == s)
                                s_d.stage[CAP_W-1-BYTE_W*s -: BYTE_W] = byte_nx;
                        end
                        if (s_q.word_idx == WIDX_W'(LINE_WORDS)) begin
                            s_d.state = ST_IDLE;
                            if (!s_d.err) begin
                                s_d.valid = 1'b1;
                                s_d.data  = s_d.stage;
                            end
                        end else begin
                            s_d.word_idx = s_q.word_idx + 1'b1;
                        end
                    end else begin
                        s_d.bit_idx = s_q.bit_idx + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (line_arm_i) begin
            s_d.state    = ST_HUNT;
            s_d.hunt_cnt = '0;
            s_d.hunt_sr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign resync_o = (s_q.state != ST_DATA);
    assign valid_o  = s_q.valid;
    assign data_o   = s_q.data;

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(half_en_i));

    p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o);

    p_hunt_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_HUNT) |-> (s_q.hunt_cnt < CNT_W'(SEARCH_HALVES)));

endmodule

// File: rtl/avail_driver.sv
module avail_driver #(
    parameter int PULSE_CYC = 20,
    localparam int PC_W     = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_start_i,
    input  logic line_arm_i,
    input  logic valid_i,
    output logic avail_n_o
);

    typedef struct packed {
        logic            flag;
        logic [PC_W-1:0] cnt;
    } av_t;

    av_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (valid_i)       a_d.flag = 1'b1;
        if (field_start_i) a_d.flag = 1'b0;
        if (line_arm_i)            a_d.cnt = PC_W'(PULSE_CYC);
        else if (a_q.cnt != '0)    a_d.cnt = a_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign avail_n_o = ~(a_q.flag | (a_q.cnt != '0));

    p_avail_on_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !field_start_i) |=> !avail_n_o);

    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_arm_i |=> !avail_n_o);

endmodule

// File: rtl/vline_word_decoder.sv
module vline_word_decoder #(
    parameter logic [7:0] START_CODE    = 8'h5D,
    parameter int         SEARCH_HALVES = 160,
    parameter int         PULSE_CYC     = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        field_start,
    input  logic        line_arm,
    input  logic        half_en,
    input  logic        half_bit,
    output logic        word_valid,
    output logic [39:0] word_data,
    output logic        avail_n
);

    logic resync, bit_stb, bit_val, bit_err;

    bp_pair_decoder u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .resync_i  (resync),
        .half_en_i (half_en),
        .half_i    (half_bit),
        .bit_stb_o (bit_stb),
        .bit_o     (bit_val),
        .bit_err_o (bit_err)
    );

    line_sequencer #(
        .START_CODE    (START_CODE),
        .SEARCH_HALVES (SEARCH_HALVES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_arm_i (line_arm),
        .half_en_i  (half_en),
        .half_i     (half_bit),
        .bit_stb_i  (bit_stb),
        .bit_i      (bit_val),
        .bit_err_i  (bit_err),
        .resync_o   (resync),
        .valid_o    (word_valid),
        .data_o     (word_data)
    );

    avail_driver #(
        .PULSE_CYC (PULSE_CYC)
    ) u_avail (
        .clk           (clk),
        .rst_n         (rst_n),
        .field_start_i (field_start),
        .line_arm_i    (line_arm),
        .valid_i       (word_valid),
        .avail_n_o     (avail_n)
    );

endmodule

// File: tb/vline_word_decoder_bench.sv
module vline_word_decoder_bench;

    localparam int PULSE = 20;
    localparam int WIN   = 160;
    localparam logic [7:0] CODE = 8'h5D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_start = 1'b0, line_arm = 1'b0, half_en = 1'b0, half_bit = 1'b0;
    logic word_valid, avail_n;
    logic [39:0] word_data;

    int checks = 0;
    int failures = 0;
    int vcount = 0;
    logic [7:0] pay [16];

    always #5 clk = ~clk;

    vline_word_decoder #(.START_CODE(CODE), .SEARCH_HALVES(WIN), .PULSE_CYC(PULSE)) u_vline_word_decoder (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_arm(line_arm),
        .half_en(half_en), .half_bit(half_bit), .word_valid(word_valid),
        .word_data(word_data), .avail_n(avail_n)
    );

    always @(posedge clk) if (rst_n && word_valid) vcount <= vcount + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] expect_word();
        return {pay[11], pay[12], pay[13], pay[14], pay[5]};
    endfunction

    task automatic send_half(input logic b);
        @(negedge clk); half_bit = b; half_en = 1'b1;
        @(negedge clk); half_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int err_bit);
        for (int i = 7; i >= 0; i--) begin
            send_half(b[i]);
            send_half((i == err_bit) ? b[i] : ~b[i]);
        end
    endtask

    task automatic arm();
        @(negedge clk); line_arm = 1'b1;
        @(negedge clk); line_arm = 1'b0;
    endtask

    task automatic field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic send_line(input int err_w, input int err_b, input bit extra);
        if (extra) send_half(1'b1);
        send_byte(8'h55, -1);
        send_byte(CODE, -1);
        for (int w = 3; w <= 15; w++) send_byte(pay[w], (w == err_w) ? err_b : -1);
    endtask

    task automatic fill(input int seed);
        for (int w = 0; w < 16; w++) pay[w] = 8'((w * 37 + seed * 53 + 11) & 255);
    endtask

    task automatic t_reset();
        chk(avail_n == 1'b1, "R9 avail_n after reset", 64'(avail_n), 64'd1);
        chk(word_valid == 1'b0, "R9 word_valid after reset", 64'(word_valid), 64'd0);
        chk(word_data == 40'd0, "R9 word_data after reset", 64'(word_data), 64'd0);
    endtask

    task automatic t_pulse();
        arm();
        chk(avail_n == 1'b0, "R8 pulse first cycle", 64'(avail_n), 64'd0);
        repeat (PULSE - 1) @(negedge clk);
        chk(avail_n == 1'b0, "R8 pulse last cycle", 64'(avail_n), 64'd0);
        @(negedge clk);
        chk(avail_n == 1'b1, "R8 pulse ended", 64'(avail_n), 64'd1);
    endtask

    task automatic t_good(input int seed, input bit extra);
        int v0;
        fill(seed);
        v0 = vcount;
        arm();
        send_line(-1, -1, extra);
        chk(vcount == v0 + 1, "R5 one strobe per good line", 64'(vcount - v0), 64'd1);
        chk(word_data == expect_word(), "R4 word order and R3 bit pairing", 64'(word_data), 64'(expect_word()));
        chk(avail_n == 1'b0, "R7 avail_n low after strobe", 64'(avail_n), 64'd0);
    endtask

    task automatic t_strobe_timing();
        fill(7);
        field();
        arm();
        send_byte(8'h55, -1);
        send_byte(CODE, -1);
        for (int w = 3; w <= 14; w++) send_byte(pay[w], -1);
        for (int i = 7; i >= 1; i--) begin
            send_half(pay[15][i]);
            send_half(~pay[15][i]);
        end
        send_half(pay[15][0]);
        @(negedge clk); half_bit = ~pay[15][0]; half_en = 1'b1;
        @(negedge clk); half_en = 1'b0;
        chk(word_valid == 1'b1, "R5 strobe one cycle after last half", 64'(word_valid), 64'd1);
        chk(word_data == expect_word(), "R5 data with strobe", 64'(word_data), 64'(expect_word()));
        @(negedge clk);
        chk(word_valid == 1'b0, "R5 strobe lasts one cycle", 64'(word_valid), 64'd0);
        chk(avail_n == 1'b0, "R7 avail_n low one cycle after strobe", 64'(avail_n), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_field_clear();
        field();
        chk(avail_n == 1'b1, "R7 field_start raises avail_n", 64'(avail_n), 64'd1);
    endtask

    task automatic t_err(input int w, input int b, input string tag);
        logic [39:0] keep;
        int v0;
        keep = word_data;
        v0 = vcount;
        fill(w + 3);
        arm();
        send_line(w, b, 1'b0);
        chk(vcount == v0, {tag, " no strobe"}, 64'(vcount - v0), 64'd0);
        chk(word_data == keep, {tag, " data kept"}, 64'(word_data), 64'(keep));
    endtask

    task automatic t_no_arm();
        int v0;
        v0 = vcount;
        fill(9);
        send_line(-1, -1, 1'b0);
        chk(vcount == v0, "R1 no strobe without arm", 64'(vcount - v0), 64'd0);
    endtask

    task automatic t_timeout();
        int v0;
        v0 = vcount;
        fill(11);
        arm();
        for (int i = 0; i < WIN; i++) send_half(1'b0);
        send_byte(CODE, -1);
        for (int w = 3; w <= 15; w++) send_byte(pay[w], -1);
        chk(vcount == v0, "R2 search window abort", 64'(vcount - v0), 64'd0);
    endtask

    task automatic t_rearm();
        int v0;
        v0 = vcount;
        fill(13);
        arm();
        send_byte(8'h55, -1);
        send_byte(CODE, -1);
        for (int w = 3; w <= 8; w++) send_byte(pay[w], -1);
        fill(14);
        arm();
        send_line(-1, -1, 1'b0);
        chk(vcount == v0 + 1, "R1 rearm restarts line", 64'(vcount - v0), 64'd1);
        chk(word_data == expect_word(), "R1 rearm data", 64'(word_data), 64'(expect_word()));
    endtask

    task automatic t_other_words();
        logic [39:0] ref_w;
        int v0;
        fill(21);
        ref_w = expect_word();
        for (int w = 3; w <= 15; w++)
            if (!(w == 5 || (w >= 11 && w <= 14))) pay[w] = ~pay[w];
        v0 = vcount;
        arm();
        send_line(-1, -1, 1'b1);
        chk(vcount == v0 + 1, "R3 strobe with other bytes changed", 64'(vcount - v0), 64'd1);
        chk(word_data == ref_w, "R3 other bytes ignored", 64'(word_data), 64'(ref_w));
    endtask

    initial begin
        #1_900_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_pulse();
        t_good(1, 1'b0);
        t_field_clear();
        t_good(2, 1'b1);
        t_strobe_timing();
        t_err(12, 3, "R6 error in kept byte 12");
        t_err(7, 0, "R6 error in dropped byte 7");
        t_no_arm();
        t_timeout();
        t_rearm();
        t_other_words();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule